// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block feeds a two-bus DMA datapath from a chain of transfer descriptors kept in memory. After a start pulse with the address of the first descriptor, it reads each descriptor one word at a time through a plain memory read port. It checks the descriptor and presents the working transfer fields to the datapath: control word, byte count, local-side address and remote-side address. It then waits until the datapath reports that the byte count has been moved.

A descriptor is seven 32-bit words. The next-descriptor word both links the chain and ends it. When its bit 0 is set, the descriptor is the last one. Otherwise its upper bits, with the low four bits cleared, give the 16-byte-aligned base of the next descriptor. Descriptors that break the rules are never handed to the datapath. Instead the sequencer stops and reports an error code.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `xfer_valid` and `mem_req` are all low and `err_code` is 0.
- R2: A descriptor is read as seven single-word reads at consecutive word addresses (base, base+4, ... base+24), one outstanding at a time. The transfer outputs load only after the seventh word returns, so the k-th transfer of a run appears after exactly 7*k reads.
- R3: Word offsets within a descriptor: 0 is the control word, 1 the byte count (low 24 bits go to `cur_count`), 2 the local address and 4 the remote address. Words 3 and 5 have no effect on any output.
- R4: `dir_to_remote` equals bit 31 of the loaded control word: 1 moves data local to remote, 0 remote to local.
- R5: Word 6 is the next pointer. If its bit 0 is 1, the run ends with `done`=1 after that descriptor's transfer completes. Otherwise the next descriptor is fetched from the pointer with bits [3:0] cleared.
- R6: While `xfer_valid` is high and `xfer_done` is low, all transfer outputs stay unchanged. No further read is issued until `xfer_done` is seen.
- R7: A byte-count word that is zero or at least 2^24 is rejected: no transfer, `err`=1, `err_code`=1.
- R8: A descriptor whose local and remote addresses differ in bits [2:0] is rejected with `err_code`=2.
- R9: A misaligned pointer gives `err_code`=3 with no transfer. This covers a start pointer with any of bits [3:0] set, which is rejected with no read at all, and a next pointer with any of bits [3:1] set. When several faults coexist, code 1 wins over 2 and 2 over 3. `err` halts the run.
- R10: `go` is ignored while `busy` is high. `go` in idle clears `done` and `err` at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, sampled when idle |
| start_ptr | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| xfer_done | input | 1 | Datapath finished the current byte count |
| xfer_valid | output | 1 | Transfer fields are loaded and valid |
| cur_ctrl | output | 32 | Control word of the current descriptor |
| cur_count | output | CNT_W | Byte count of the current descriptor |
| cur_local | output | AW | Local-side address |
| cur_remote | output | AW | Remote-side address |
| dir_to_remote | output | 1 | Transfer direction from control bit 31 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last descriptor completed, held until the next go |
| err | output | 1 | Run halted on a fault, held until the next go |
| err_code | output | 2 | 1 count, 2 address low bits, 3 pointer alignment |

## Verification
A read index that drifts shows up within one descriptor as a wrong field on the transfer outputs, or as a read count other than 7*k when `xfer_valid` rises. A stale last-descriptor flag or next base shows at the end of that descriptor's transfer: the run ends early, runs on into a rejected descriptor, or fetches words that do not match the expected fields. Fault priority and the pointer mask are exercised with descriptors that carry several faults at once. In each case the wrong code or an unexpected transfer is visible the cycle after the seventh word returns.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 7;
  // word offsets the sequencer decodes
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_COUNT  = 1;
  localparam int unsigned OFS_LOCAL  = 2;
  localparam int unsigned OFS_REMOTE = 4;
  localparam int unsigned OFS_NEXT   = 6;
  localparam int unsigned DIR_BIT    = 31;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_COUNT = 2'd1,
    FLT_MATCH = 2'd2,
    FLT_PTR   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_XFER  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dcs_desc_fetch.sv
`timescale 1ns/1ps
module dcs_desc_fetch #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [AW-1:0]               base,
  output logic                        mem_req,
  output logic [AW-1:0]               mem_addr,
  input  logic                        mem_rvalid,
  input  logic [DW-1:0]               mem_rdata,
  output logic [NWORDS-1:0][DW-1:0]   words,
  output logic                        fetched
);
  localparam int unsigned IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int unsigned LSB_W = $clog2(DW / 8);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic             active;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      idx      <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      fetched  <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      fetched <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        idx      <= '0;
        mem_req  <= 1'b1;
        mem_addr <= base;
      end else if (active && mem_rvalid) begin
        if (idx == LAST) begin
          active  <= 1'b0;
          fetched <= 1'b1;
        end else begin
          idx      <= idx + 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= mem_addr + STEP;
        end
      end
    end
  end

  // shadow buffer, no reset, filled word by word
  always_ff @(posedge clk) begin
    if (active && mem_rvalid) words[idx] <= mem_rdata;
  end

  // R2
  word_aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[LSB_W-1:0] == '0));

  // R2
  quiet_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    fetched |-> (!mem_req && !active));
endmodule

// File: rtl/dcs_desc_check.sv
`timescale 1ns/1ps
module dcs_desc_check
  import dcs_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned MATCH_BITS = 3,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic [DW-1:0] count_word,
  input  logic [DW-1:0] local_word,
  input  logic [DW-1:0] remote_word,
  input  logic [DW-1:0] next_word,
  output fault_e        fault
);
  logic cnt_zero, cnt_big, low_diff, ptr_bad;

  always_comb begin
    cnt_zero = (count_word == '0);
    cnt_big  = (count_word[DW-1:CNT_W] != '0);
    low_diff = (local_word[MATCH_BITS-1:0] != remote_word[MATCH_BITS-1:0]);
    ptr_bad  = !next_word[0] && (next_word[ALIGN_BITS-1:1] != '0);
    if (next_word[0]) ptr_bad = (next_word[ALIGN_BITS-1:1] != '0);
    if (cnt_zero || cnt_big) fault = FLT_COUNT;
    else if (low_diff)       fault = FLT_MATCH;
    else if (ptr_bad)        fault = FLT_PTR;
    else                     fault = FLT_NONE;
  end
endmodule

// File: rtl/dma_chain_seq.sv
`timescale 1ns/1ps
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned MATCH_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [AW-1:0]     start_ptr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              xfer_done,
  output logic              xfer_valid,
  output logic [31:0]       cur_ctrl,
  output logic [CNT_W-1:0]  cur_count,
  output logic [AW-1:0]     cur_local,
  output logic [AW-1:0]     cur_remote,
  output logic              dir_to_remote,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);
  localparam int unsigned DW = WORD_W;

  seq_state_e                     state;
  logic                           fetch_start;
  logic [AW-1:0]                  fetch_base;
  logic [AW-1:0]                  next_base;
  logic                           last_q;
  logic [DESC_WORDS-1:0][DW-1:0]  words;
  logic                           fetched;
  fault_e                         fault;
  logic                           start_misaligned;

  assign start_misaligned = (start_ptr[ALIGN_BITS-1:0] != '0);
  assign busy = (state != SQ_IDLE);

  dcs_desc_fetch #(.AW(AW), .DW(DW), .NWORDS(DESC_WORDS)) u_fetch (
    .clk(clk), .rst(rst), .start(fetch_start), .base(fetch_base),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .words(words), .fetched(fetched)
  );

  dcs_desc_check #(.DW(DW), .CNT_W(CNT_W), .MATCH_BITS(MATCH_BITS),
                   .ALIGN_BITS(ALIGN_BITS)) u_check (
    .count_word(words[OFS_COUNT]), .local_word(words[OFS_LOCAL]),
    .remote_word(words[OFS_REMOTE]), .next_word(words[OFS_NEXT]),
    .fault(fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= SQ_IDLE;
      fetch_start   <= 1'b0;
      fetch_base    <= '0;
      next_base     <= '0;
      last_q        <= 1'b0;
      xfer_valid    <= 1'b0;
      cur_ctrl      <= '0;
      cur_count     <= '0;
      cur_local     <= '0;
      cur_remote    <= '0;
      dir_to_remote <= 1'b0;
      done          <= 1'b0;
      err           <= 1'b0;
      err_code      <= FLT_NONE;
    end else begin
      fetch_start <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (go) begin
            done <= 1'b0;
            if (start_misaligned) begin
              err      <= 1'b1;
              err_code <= FLT_PTR;
            end else begin
              err         <= 1'b0;
              err_code    <= FLT_NONE;
              fetch_start <= 1'b1;
              fetch_base  <= start_ptr;
              state       <= SQ_FETCH;
            end
          end
        end
        SQ_FETCH: begin
          if (fetched) begin
            if (fault != FLT_NONE) begin
              err      <= 1'b1;
              err_code <= fault;
              state    <= SQ_IDLE;
            end else begin
              cur_ctrl      <= words[OFS_CTRL];
              cur_count     <= words[OFS_COUNT][CNT_W-1:0];
              cur_local     <= words[OFS_LOCAL][AW-1:0];
              cur_remote    <= words[OFS_REMOTE][AW-1:0];
              dir_to_remote <= words[OFS_CTRL][DIR_BIT];
              last_q        <= words[OFS_NEXT][0];
              next_base     <= {words[OFS_NEXT][AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
              xfer_valid    <= 1'b1;
              state         <= SQ_XFER;
            end
          end
        end
        SQ_XFER: begin
          if (xfer_done) begin
            xfer_valid <= 1'b0;
            if (last_q) begin
              done  <= 1'b1;
              state <= SQ_IDLE;
            end else begin
              fetch_start <= 1'b1;
              fetch_base  <= next_base;
              state       <= SQ_FETCH;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R6
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(cur_count) &&
      $stable(cur_local) && $stable(cur_remote) && $stable(cur_ctrl)));

  // R6
  no_read_during_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> !mem_req);

  // R7
  legal_count_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (cur_count != '0));

  // R8
  low_bits_match_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (cur_local[MATCH_BITS-1:0] == cur_remote[MATCH_BITS-1:0]));

  // R9
  halt_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !xfer_valid && !mem_req && err_code != FLT_NONE));

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!err && !busy));
endmodule

// File: tb/dma_chain_seq_tb.sv
`timescale 1ns/1ps
module dma_chain_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [31:0] go_ptr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xfer_done = 1'b0;
  logic        xfer_valid;
  logic [31:0] cur_ctrl;
  logic [23:0] cur_count;
  logic [31:0] cur_local, cur_remote;
  logic        dir_to_remote, busy, done, err;
  logic [1:0]  err_code;

  dma_chain_seq u_dut (
    .clk(clk), .rst(rst), .go(go), .start_ptr(go_ptr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_done(xfer_done), .xfer_valid(xfer_valid),
    .cur_ctrl(cur_ctrl), .cur_count(cur_count),
    .cur_local(cur_local), .cur_remote(cur_remote),
    .dir_to_remote(dir_to_remote), .busy(busy), .done(done),
    .err(err), .err_code(err_code)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] ctrl;
    logic [31:0] count;
    logic [31:0] loc;
    logic [31:0] rem;
    int          reads;
  } xfer_item_t;

  xfer_item_t  sb_q[$];
  xfer_item_t  cur_it;
  logic [31:0] mem [256];
  int total = 0;
  int bad = 0;
  int lat = 0;
  int wait_n = 0;
  int req_cnt = 0;
  int hold_cfg = 2;
  int hold_n = 0;
  bit seen = 0;
  int cycles = 0;
  logic [31:0] pend_addr = '0;

  task automatic chk_eq(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory model: one outstanding read, latency set by lat
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (wait_n > 0) begin
      wait_n--;
      if (wait_n == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[pend_addr[9:2]];
      end
    end
    if (mem_req) begin
      req_cnt++;
      pend_addr = mem_addr;
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[mem_addr[9:2]];
      end else begin
        wait_n = lat;
      end
    end
  end

  // monitor: pops expected transfers, holds them, then signals completion
  always @(negedge clk) begin
    xfer_done = 1'b0;
    if (!xfer_valid) begin
      seen = 0;
    end else if (!seen) begin
      seen = 1;
      hold_n = hold_cfg;
      if (sb_q.size() == 0) begin
        chk_eq("R9", "unexpected transfer", 32'd1, 32'd0);
        cur_it = '{ctrl: cur_ctrl, count: 32'(cur_count), loc: cur_local, rem: cur_remote, reads: 0};
      end else begin
        cur_it = sb_q.pop_front();
        chk_eq("R2", "reads before load", 32'(req_cnt), 32'(cur_it.reads));
        chk_eq("R3", "ctrl", cur_ctrl, cur_it.ctrl);
        chk_eq("R3", "count", 32'(cur_count), cur_it.count);
        chk_eq("R3", "local", cur_local, cur_it.loc);
        chk_eq("R3", "remote", cur_remote, cur_it.rem);
        chk_eq("R4", "direction", 32'(dir_to_remote), 32'(cur_it.ctrl[31]));
      end
    end else begin
      chk_eq("R6", "count held", 32'(cur_count), cur_it.count);
      chk_eq("R6", "no read while held", 32'(mem_req), 32'd0);
      if (hold_n > 0) hold_n--;
      if (hold_n == 0) xfer_done = 1'b1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic put_desc(input int base, input logic [31:0] ctrl,
                          input logic [31:0] cnt, input logic [31:0] loc,
                          input logic [31:0] rem, input logic [31:0] nxt);
    int w;
    w = base >> 2;
    mem[w]     = ctrl;
    mem[w + 1] = cnt;
    mem[w + 2] = loc;
    mem[w + 3] = 32'hDEAD_0003;
    mem[w + 4] = rem;
    mem[w + 5] = 32'hBEEF_0005;
    mem[w + 6] = nxt;
  endtask

  task automatic expect_xfer(input logic [31:0] ctrl, input logic [31:0] cnt,
                             input logic [31:0] loc, input logic [31:0] rem,
                             input int reads);
    xfer_item_t it;
    it = '{ctrl: ctrl, count: cnt, loc: loc, rem: rem, reads: reads};
    sb_q.push_back(it);
  endtask

  task automatic run_chain(input logic [31:0] sp, input logic exp_done,
                           input logic exp_err, input logic [1:0] exp_code,
                           input string rq, input bit poke);
    req_cnt = 0;
    go_ptr = sp;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (sp[3:0] == 4'h0) begin
      chk_eq("R10", "flags cleared by go", {30'd0, done, err}, 32'd0);
      chk_eq("R10", "busy after go", 32'(busy), 32'd1);
    end
    if (poke) begin
      repeat (6) @(negedge clk);
      go_ptr = 32'h0000_0004;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk_eq("R10", "go while busy ignored", 32'(err), 32'd0);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk_eq(rq, "done", 32'(done), 32'(exp_done));
    chk_eq(rq, "err", 32'(err), 32'(exp_err));
    chk_eq(rq, "err_code", 32'(err_code), 32'(exp_code));
    chk_eq(rq, "pending transfers", 32'(sb_q.size()), 32'd0);
    sb_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1", "busy", 32'(busy), 32'd0);
    chk_eq("R1", "done/err", {30'd0, done, err}, 32'd0);
    chk_eq("R1", "xfer_valid/mem_req", {30'd0, xfer_valid, mem_req}, 32'd0);
    chk_eq("R1", "err_code", 32'(err_code), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R5 single descriptor, local to remote
    lat = 0; hold_cfg = 2;
    put_desc(32'h40, 32'h8001_2345, 32'h100, 32'h1000_0004, 32'h2000_0014, 32'h1);
    expect_xfer(32'h8001_2345, 32'h100, 32'h1000_0004, 32'h2000_0014, 7);
    run_chain(32'h40, 1'b1, 1'b0, 2'd0, "R5", 1'b0);

    // R5 three descriptor chain, mixed direction, count at max legal
    lat = 3; hold_cfg = 4;
    put_desc(32'h80, 32'h0000_0000, 32'h00FF_FFFF, 32'h0000_1000, 32'h8000_2000, 32'h0000_00C0);
    put_desc(32'hC0, 32'h8000_0000, 32'h4, 32'h0000_3007, 32'h0000_4447, 32'h0000_0100);
    put_desc(32'h100, 32'h0000_0ABC, 32'h18, 32'h1111_1112, 32'h2222_2222, 32'h0000_0141);
    expect_xfer(32'h0000_0000, 32'h00FF_FFFF, 32'h0000_1000, 32'h8000_2000, 7);
    expect_xfer(32'h8000_0000, 32'h4, 32'h0000_3007, 32'h0000_4447, 14);
    expect_xfer(32'h0000_0ABC, 32'h18, 32'h1111_1112, 32'h2222_2222, 21);
    run_chain(32'h80, 1'b1, 1'b0, 2'd0, "R5", 1'b0);

    // R10 same chain with go pulsed mid-run
    lat = 1; hold_cfg = 3;
    expect_xfer(32'h0000_0000, 32'h00FF_FFFF, 32'h0000_1000, 32'h8000_2000, 7);
    expect_xfer(32'h8000_0000, 32'h4, 32'h0000_3007, 32'h0000_4447, 14);
    expect_xfer(32'h0000_0ABC, 32'h18, 32'h1111_1112, 32'h2222_2222, 21);
    run_chain(32'h80, 1'b1, 1'b0, 2'd0, "R10", 1'b1);

    // R7 zero count
    lat = 0;
    put_desc(32'h140, 32'h8000_0000, 32'h0, 32'h10, 32'h20, 32'h1);
    run_chain(32'h140, 1'b0, 1'b1, 2'd1, "R7", 1'b0);
    // R7 count of 2^24
    put_desc(32'h180, 32'h8000_0000, 32'h0100_0000, 32'h10, 32'h20, 32'h1);
    run_chain(32'h180, 1'b0, 1'b1, 2'd1, "R7", 1'b0);

    // R8 low address bits differ
    put_desc(32'h1C0, 32'h0, 32'h40, 32'h0000_0011, 32'h0000_0022, 32'h1);
    run_chain(32'h1C0, 1'b0, 1'b1, 2'd2, "R8", 1'b0);

    // R9 next pointer with bit 3 set
    put_desc(32'h200, 32'h0, 32'h40, 32'h0000_0010, 32'h0000_0020, 32'h0000_0188);
    run_chain(32'h200, 1'b0, 1'b1, 2'd3, "R9", 1'b0);

    // R9 misaligned start pointer: no reads at all
    run_chain(32'h48, 1'b0, 1'b1, 2'd3, "R9", 1'b0);
    chk_eq("R9", "reads on bad start", 32'(req_cnt), 32'd0);

    // R9 priority: count beats match beats pointer
    put_desc(32'h240, 32'h0, 32'h0, 32'h1, 32'h2, 32'h0000_0006);
    run_chain(32'h240, 1'b0, 1'b1, 2'd1, "R9", 1'b0);
    put_desc(32'h280, 32'h0, 32'h8, 32'h1, 32'h2, 32'h0000_0006);
    run_chain(32'h280, 1'b0, 1'b1, 2'd2, "R9", 1'b0);

    // R7 chain: good first descriptor, second rejected after one transfer
    lat = 2; hold_cfg = 1;
    put_desc(32'h2C0, 32'h8000_00AA, 32'h20, 32'h0000_5005, 32'h0000_6665, 32'h0000_0140);
    expect_xfer(32'h8000_00AA, 32'h20, 32'h0000_5005, 32'h0000_6665, 7);
    run_chain(32'h2C0, 1'b0, 1'b1, 2'd1, "R7", 1'b0);
    chk_eq("R2", "reads in two fetches", 32'(req_cnt), 32'd14);

    finish_run();
  end
endmodule